// File: doc/BRIEF.md
# Programmable Address Region Decoder

This block sorts every CPU access into the resource that must answer it. It holds sixteen region descriptors. Each descriptor describes a window in either memory space or I/O space and names a target: the DRAM window, one of three ROM/flash selects, or one of eight general-purpose bus chip selects. The access address and its space flag are decoded combinationally. The block drives a one-hot set of select lines, reports the target code and the winning region, and gives the memory attributes of that region: cacheable, write-protected and no-execute.

Memory regions are counted in 4 KB pages and I/O regions in single bytes. When several enabled regions overlap, the region with the lowest number wins. An access that no region claims goes to a default target. The internal configuration register window is 4 KB long and starts at a page base that software can relocate. This window is checked before any region.

A write to a write-protected region, or an instruction fetch from a no-execute region, is blocked: no select line is asserted. The violation is also reported on a flag one clock later. Descriptors and the window base are loaded through a single-cycle write port.

Top module: `addr_region_decoder`

## Requirements
- R1: After synchronous reset, every descriptor is cleared to disabled, the configuration window base is page 0x000FF, `viol_wp` and `viol_nx` are 0, and any access returns the default target with every attribute 0.
- R2: A descriptor is written with `cfg_we` high, `cfg_addr` = region index 0..15, and `cfg_wdata` laid out as follows: bit 0 enable, bit 1 space (1 = I/O), bits 5:2 target code, bit 6 cacheable, bit 7 write-protect, bit 8 no-execute, bits 28:9 size, bits 48:29 base. The region matches a unit address U when base <= U < base + size. U is `acc_addr[31:12]` in memory space and `acc_addr[15:0]` in I/O space.
- R3: A region matches only accesses whose `acc_io` equals its space bit.
- R4: When several enabled regions match, `hit_idx` and the outputs follow the lowest-numbered region, and `hit_valid` is 1.
- R5: An access that no region matches has `hit_valid` = 0, target 0 (DRAM) in memory space or target 13 (external I/O) in I/O space, and all attributes 0.
- R6: Target codes are 0 DRAM, 1..3 ROM selects 0..2, 4..11 bus chip selects 0..7, 12 configuration window, 13 external I/O. Exactly the select line of `tgt_code` is high while `acc_valid` is 1 and the access is not blocked; otherwise all selects are low.
- R7: On a memory-region hit, `attr_cache`, `attr_wp` and `attr_nx` equal that region's bits. For an I/O access they are 0.
- R8: A write (`acc_write` = 1) that resolves to write-protect raises `acc_block` at once, suppresses all selects, and sets `viol_wp` for exactly the next cycle. Reads of the same region are not blocked.
- R9: A fetch (`acc_fetch` = 1, `acc_write` = 0) that resolves to no-execute raises `acc_block`, suppresses all selects, and sets `viol_nx` for exactly the next cycle. Data reads are not blocked.
- R10: Writing `cfg_addr` = 16 loads the configuration window base page from `cfg_wdata[19:0]`. A memory access inside that page gives target 12, `hit_valid` = 0 and no attributes, even when a region also covers the page. I/O accesses never hit it.
- R11: A region whose target code is 12..15 or whose size is 0 never matches.
- R12: Writes with `cfg_addr` 17..31 change no descriptor and do not change the window base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor/base write strobe |
| cfg_addr | input | 5 | Write index: 0..15 region, 16 window base |
| cfg_wdata | input | 49 | Write data |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access address |
| acc_io | input | 1 | 1 = I/O space, 0 = memory space |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| tgt_code | output | 4 | Resolved target code |
| hit_valid | output | 1 | A region descriptor decided the target |
| hit_idx | output | 4 | Winning region index |
| attr_cache | output | 1 | Cacheable attribute |
| attr_wp | output | 1 | Write-protect attribute |
| attr_nx | output | 1 | No-execute attribute |
| acc_block | output | 1 | Access blocked by protection |
| sel_dram | output | 1 | DRAM select |
| sel_rom | output | 3 | ROM/flash selects |
| sel_gp | output | 8 | Bus chip selects |
| sel_cfg | output | 1 | Configuration window select |
| sel_ext | output | 1 | External I/O select |
| viol_wp | output | 1 | Registered write-protect violation |
| viol_nx | output | 1 | Registered no-execute violation |

## Verification
Directed edge patterns place accesses one unit below, at, inside and one unit past a window. This separates an off-by-one in the lower or the upper bound, in both page and byte granularity. Stacked regions that share a range but name different targets show whether priority runs from the low end. A memory page and an I/O byte with the same numeric value show whether the space bit is honoured. Random descriptor sets with random write/fetch mixes then explore overlaps, reserved codes, zero sizes and window relocation, and each outcome is compared with a bench model.

// File: rtl/ard_pkg.sv
package ard_pkg;
  localparam int NROM = 3;
  localparam int NGP  = 8;
  localparam int TGT_W = 4;
  localparam int NSEL = NROM + NGP + 3;

  localparam logic [TGT_W-1:0] TGT_DRAM        = 4'd0;
  localparam logic [TGT_W-1:0] TGT_ROM0        = 4'd1;
  localparam logic [TGT_W-1:0] TGT_GP0         = TGT_ROM0 + 4'(NROM);
  localparam logic [TGT_W-1:0] TGT_LAST_REGION = TGT_GP0 + 4'(NGP) - 4'd1;
  localparam logic [TGT_W-1:0] TGT_CFG         = TGT_LAST_REGION + 4'd1;
  localparam logic [TGT_W-1:0] TGT_EXT         = TGT_CFG + 4'd1;

  localparam int F_EN    = 0;
  localparam int F_IO    = 1;
  localparam int F_TGT   = 2;
  localparam int F_CACHE = 6;
  localparam int F_WP    = 7;
  localparam int F_NX    = 8;
  localparam int F_SIZE  = 9;

  typedef struct packed {
    logic cache;
    logic wp;
    logic nx;
  } attr_t;
endpackage

// File: rtl/ard_desc_bank.sv
module ard_desc_bank
  import ard_pkg::*;
#(
  parameter int NREG = 16,
  parameter int UW   = 20,
  parameter int AIW  = 5,
  parameter int DW   = F_SIZE + 2 * UW,
  parameter logic [UW-1:0] CFG_RST = 'h000FF
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [AIW-1:0]                cfg_addr,
  input  logic [DW-1:0]                 cfg_wdata,
  output logic [NREG-1:0]               d_en,
  output logic [NREG-1:0]               d_io,
  output logic [NREG-1:0][TGT_W-1:0]    d_tgt,
  output attr_t [NREG-1:0]              d_attr,
  output logic [NREG-1:0][UW-1:0]       d_base,
  output logic [NREG-1:0][UW-1:0]       d_size,
  output logic [UW-1:0]                 cfg_base
);
  localparam int F_BASE = F_SIZE + UW;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic hit_w;
    assign hit_w = cfg_we && (cfg_addr == AIW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        d_en[g]   <= 1'b0;
        d_io[g]   <= 1'b0;
        d_tgt[g]  <= '0;
        d_attr[g] <= '0;
        d_base[g] <= '0;
        d_size[g] <= '0;
      end else if (hit_w) begin
        d_en[g]         <= cfg_wdata[F_EN];
        d_io[g]         <= cfg_wdata[F_IO];
        d_tgt[g]        <= cfg_wdata[F_TGT +: TGT_W];
        d_attr[g].cache <= cfg_wdata[F_CACHE];
        d_attr[g].wp    <= cfg_wdata[F_WP];
        d_attr[g].nx    <= cfg_wdata[F_NX];
        d_size[g]       <= cfg_wdata[F_SIZE +: UW];
        d_base[g]       <= cfg_wdata[F_BASE +: UW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_base <= CFG_RST;
    else if (cfg_we && (cfg_addr == AIW'(NREG)))
      cfg_base <= cfg_wdata[UW-1:0];
  end
endmodule

// File: rtl/ard_region_match.sv
module ard_region_match
  import ard_pkg::*;
#(
  parameter int UW = 20
) (
  input  logic             en,
  input  logic             io,
  input  logic [TGT_W-1:0] tgt,
  input  logic [UW-1:0]    base,
  input  logic [UW-1:0]    size,
  input  logic [UW-1:0]    mem_unit,
  input  logic [UW-1:0]    io_unit,
  input  logic             acc_io,
  output logic             match
);
  logic [UW-1:0] unit;
  logic [UW-1:0] offs;

  assign unit = io ? io_unit : mem_unit;
  assign offs = unit - base;

  assign match = en && (io == acc_io) && (tgt <= TGT_LAST_REGION) &&
                 (size != '0) && (unit >= base) && (offs < size);
endmodule

// File: rtl/ard_prio_sel.sv
module ard_prio_sel #(
  parameter int NREG = 16,
  parameter int IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0] match,
  output logic            found,
  output logic [IW-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ard_viol_reg.sv
module ard_viol_reg (
  input  logic clk,
  input  logic rst,
  input  logic wp_evt,
  input  logic nx_evt,
  output logic viol_wp,
  output logic viol_nx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      viol_wp <= 1'b0;
      viol_nx <= 1'b0;
    end else begin
      viol_wp <= wp_evt;
      viol_nx <= nx_evt;
    end
  end
endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
  import ard_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IO_W       = 16,
  parameter int CFG_PAGES  = 1,
  parameter logic [AW-PAGE_SHIFT-1:0] CFG_RST = 'h000FF,
  localparam int UW  = AW - PAGE_SHIFT,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AIW = $clog2(NREG + 1),
  localparam int DW  = F_SIZE + 2 * UW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AIW-1:0]   cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic             acc_io,
  input  logic             acc_write,
  input  logic             acc_fetch,
  output logic [TGT_W-1:0] tgt_code,
  output logic             hit_valid,
  output logic [IW-1:0]    hit_idx,
  output logic             attr_cache,
  output logic             attr_wp,
  output logic             attr_nx,
  output logic             acc_block,
  output logic             sel_dram,
  output logic [NROM-1:0]  sel_rom,
  output logic [NGP-1:0]   sel_gp,
  output logic             sel_cfg,
  output logic             sel_ext,
  output logic             viol_wp,
  output logic             viol_nx
);
  logic [NREG-1:0]            d_en, d_io;
  logic [NREG-1:0][TGT_W-1:0] d_tgt;
  attr_t [NREG-1:0]           d_attr;
  logic [NREG-1:0][UW-1:0]    d_base, d_size;
  logic [UW-1:0]              cfg_base;

  ard_desc_bank #(
    .NREG(NREG), .UW(UW), .AIW(AIW), .DW(DW), .CFG_RST(CFG_RST)
  ) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .d_en(d_en), .d_io(d_io), .d_tgt(d_tgt),
    .d_attr(d_attr), .d_base(d_base), .d_size(d_size), .cfg_base(cfg_base)
  );

  logic [UW-1:0] mem_unit, io_unit, cfg_offs;
  assign mem_unit = acc_addr[AW-1:PAGE_SHIFT];
  assign io_unit  = UW'(acc_addr[IO_W-1:0]);

  logic [NREG-1:0] match;
  for (genvar g = 0; g < NREG; g++) begin : g_match
    ard_region_match #(.UW(UW)) u_m (
      .en(d_en[g]), .io(d_io[g]), .tgt(d_tgt[g]), .base(d_base[g]),
      .size(d_size[g]), .mem_unit(mem_unit), .io_unit(io_unit),
      .acc_io(acc_io), .match(match[g])
    );
  end

  logic          found;
  logic [IW-1:0] win;
  ard_prio_sel #(.NREG(NREG), .IW(IW)) u_prio (
    .match(match), .found(found), .idx(win)
  );

  logic cfg_hit;
  assign cfg_offs = mem_unit - cfg_base;
  assign cfg_hit  = !acc_io && (mem_unit >= cfg_base) && (cfg_offs < UW'(CFG_PAGES));

  attr_t attr;
  always_comb begin
    attr      = '0;
    hit_valid = 1'b0;
    hit_idx   = '0;
    if (cfg_hit) begin
      tgt_code = TGT_CFG;
    end else if (found) begin
      tgt_code  = d_tgt[win];
      hit_valid = 1'b1;
      hit_idx   = win;
      if (!acc_io) attr = d_attr[win];
    end else begin
      tgt_code = acc_io ? TGT_EXT : TGT_DRAM;
    end
  end

  assign attr_cache = attr.cache;
  assign attr_wp    = attr.wp;
  assign attr_nx    = attr.nx;

  logic wp_evt, nx_evt, go;
  assign wp_evt    = acc_valid && acc_write && attr.wp;
  assign nx_evt    = acc_valid && acc_fetch && !acc_write && attr.nx;
  assign acc_block = wp_evt || nx_evt;
  assign go        = acc_valid && !acc_block;

  assign sel_dram = go && (tgt_code == TGT_DRAM);
  assign sel_cfg  = go && (tgt_code == TGT_CFG);
  assign sel_ext  = go && (tgt_code == TGT_EXT);
  for (genvar g = 0; g < NROM; g++) begin : g_rom
    assign sel_rom[g] = go && (tgt_code == TGT_ROM0 + TGT_W'(g));
  end
  for (genvar g = 0; g < NGP; g++) begin : g_gp
    assign sel_gp[g] = go && (tgt_code == TGT_GP0 + TGT_W'(g));
  end

  ard_viol_reg u_viol (
    .clk(clk), .rst(rst), .wp_evt(wp_evt), .nx_evt(nx_evt),
    .viol_wp(viol_wp), .viol_nx(viol_nx)
  );
endmodule

// File: rtl/ard_checker.sv
module ard_checker
  import ard_pkg::*;
#(
  parameter int IW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_io,
  input logic             acc_write,
  input logic             acc_fetch,
  input logic [TGT_W-1:0] tgt_code,
  input logic             hit_valid,
  input logic             attr_cache,
  input logic             attr_wp,
  input logic             attr_nx,
  input logic             acc_block,
  input logic             sel_dram,
  input logic [NROM-1:0]  sel_rom,
  input logic [NGP-1:0]   sel_gp,
  input logic             sel_cfg,
  input logic             sel_ext,
  input logic             viol_wp,
  input logic             viol_nx
);
  logic [NSEL-1:0] sels;
  assign sels = {sel_ext, sel_cfg, sel_gp, sel_rom, sel_dram};

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sels)) else $error("select lines not one-hot"); // R6

  AST_BLOCK_NOSEL: assert property (@(posedge clk) disable iff (rst)
    acc_block |-> (sels == '0)) else $error("select during block"); // R8

  AST_IO_NOATTR: assert property (@(posedge clk) disable iff (rst)
    acc_io |-> !(attr_cache || attr_wp || attr_nx)) else $error("io attrs"); // R7

  AST_CFG_NOREGION: assert property (@(posedge clk) disable iff (rst)
    (tgt_code == TGT_CFG) |-> (!hit_valid && !attr_cache && !acc_io))
    else $error("cfg window tagged as region"); // R10

  AST_WP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && attr_wp) |=> viol_wp) else $error("wp flag"); // R8

  AST_NX_FLAG: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_fetch && !acc_write && attr_nx) |=> viol_nx)
    else $error("nx flag"); // R9

  AST_IDLE_NOVIOL: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!viol_wp && !viol_nx)) else $error("spurious violation"); // R8
endmodule

bind addr_region_decoder ard_checker #(.IW(IW)) u_ard_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_io(acc_io),
  .acc_write(acc_write), .acc_fetch(acc_fetch), .tgt_code(tgt_code),
  .hit_valid(hit_valid), .attr_cache(attr_cache), .attr_wp(attr_wp),
  .attr_nx(attr_nx), .acc_block(acc_block), .sel_dram(sel_dram),
  .sel_rom(sel_rom), .sel_gp(sel_gp), .sel_cfg(sel_cfg), .sel_ext(sel_ext),
  .viol_wp(viol_wp), .viol_nx(viol_nx)
);

// File: tb/addr_region_decoder_bench.sv
module addr_region_decoder_bench;
  localparam int CLK_P = 10;
  localparam int NREG  = 16;
  localparam int UW    = 20;
  localparam int DW    = 49;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic acc_valid = 1'b0, acc_io = 1'b0, acc_write = 1'b0, acc_fetch = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [3:0] tgt_code, hit_idx;
  logic hit_valid, attr_cache, attr_wp, attr_nx, acc_block;
  logic sel_dram, sel_cfg, sel_ext, viol_wp, viol_nx;
  logic [2:0] sel_rom;
  logic [7:0] sel_gp;

  addr_region_decoder u_addr_region_decoder (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_io(acc_io), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .tgt_code(tgt_code), .hit_valid(hit_valid), .hit_idx(hit_idx),
    .attr_cache(attr_cache), .attr_wp(attr_wp), .attr_nx(attr_nx),
    .acc_block(acc_block), .sel_dram(sel_dram), .sel_rom(sel_rom),
    .sel_gp(sel_gp), .sel_cfg(sel_cfg), .sel_ext(sel_ext),
    .viol_wp(viol_wp), .viol_nx(viol_nx)
  );

  always #(CLK_P/2) clk = ~clk;

  bit m_en[NREG], m_io[NREG], m_c[NREG], m_w[NREG], m_n[NREG];
  bit [3:0] m_tgt[NREG];
  bit [UW-1:0] m_base[NREG], m_size[NREG];
  bit [UW-1:0] m_cfg = 20'h000FF;
  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(bit en, bit io, bit [3:0] t, bit c,
      bit w, bit n, bit [UW-1:0] size, bit [UW-1:0] base);
    return {base, size, n, w, c, t, io, en};
  endfunction

  task automatic wr(int idx, logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(idx); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (idx < NREG) begin
      m_en[idx] = d[0]; m_io[idx] = d[1]; m_tgt[idx] = d[5:2];
      m_c[idx] = d[6]; m_w[idx] = d[7]; m_n[idx] = d[8];
      m_size[idx] = d[28:9]; m_base[idx] = d[48:29];
    end else if (idx == NREG) begin
      m_cfg = d[UW-1:0];
    end
  endtask

  task automatic access(string req, bit [31:0] a, bit io, bit w, bit f);
    bit [UW-1:0] mu, iu, u;
    bit cfgh, fnd, ec, ew, en, blk;
    int k;
    bit [3:0] et;
    bit [13:0] esel;
    mu = a[31:12]; iu = UW'(a[15:0]);
    cfgh = !io && (mu >= m_cfg) && ((mu - m_cfg) < 1);
    fnd = 0; k = 0;
    for (int i = NREG - 1; i >= 0; i--) begin
      u = m_io[i] ? iu : mu;
      if (m_en[i] && m_io[i] == io && m_tgt[i] <= 11 && m_size[i] != 0 &&
          u >= m_base[i] && (u - m_base[i]) < m_size[i]) begin
        fnd = 1; k = i;
      end
    end
    ec = 0; ew = 0; en = 0;
    if (cfgh) et = 12;
    else if (fnd) begin
      et = m_tgt[k];
      if (!io) begin ec = m_c[k]; ew = m_w[k]; en = m_n[k]; end
    end else et = io ? 4'd13 : 4'd0;
    blk = (w && ew) || (f && !w && en);
    esel = blk ? 14'd0 : (14'd1 << et);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_io = io; acc_write = w; acc_fetch = f;
    #1;
    chk(req, "tgt_code", tgt_code, et);
    chk(req, "hit_valid", hit_valid, !cfgh && fnd);
    if (!cfgh && fnd) chk(req, "hit_idx", hit_idx, k);
    chk(req, "attrs", {attr_cache, attr_wp, attr_nx}, {ec, ew, en});
    chk(req, "selects", {sel_ext, sel_cfg, sel_gp, sel_rom, sel_dram}, esel);
    chk(req, "acc_block", acc_block, blk);
    @(posedge clk); #1;
    chk(req, "viol_wp", viol_wp, w && ew);
    chk(req, "viol_nx", viol_nx, f && !w && en);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state and R5 defaults
    chk("R1", "viol_wp", viol_wp, 0);
    chk("R1", "viol_nx", viol_nx, 0);
    access("R1", 32'h0000_5123, 0, 0, 0);
    access("R5", 32'h0000_0042, 1, 1, 0);
    access("R1", 32'h000F_F010, 0, 0, 0);        // reset window base R10
    // R2 bounds: pages 10..11 to ROM1, cacheable
    wr(2, mk(1, 0, 4'd2, 1, 0, 0, 20'd2, 20'd10));
    access("R2", 32'h0000_9FFF, 0, 0, 0);
    access("R2", 32'h0000_A000, 0, 0, 0);
    access("R2", 32'h0000_BFFF, 0, 0, 0);
    access("R2", 32'h0000_C000, 0, 0, 0);
    access("R7", 32'h0000_A800, 0, 0, 1);
    // R3 I/O region at bytes 0x10..0x13; same numbers in memory space miss
    wr(5, mk(1, 1, 4'd6, 1, 1, 1, 20'd4, 20'h10));
    access("R3", 32'h0000_0013, 1, 1, 0);
    access("R3", 32'h0001_0000, 0, 0, 0);
    access("R3", 32'h0000_0014, 1, 0, 0);
    access("R7", 32'h0000_0010, 1, 1, 1);
    // R4 overlap: region 3 beats region 7
    wr(7, mk(1, 0, 4'd9, 0, 0, 0, 20'd8, 20'd20));
    wr(3, mk(1, 0, 4'd4, 0, 0, 0, 20'd2, 20'd22));
    access("R4", 32'h0001_6000, 0, 0, 0);
    access("R4", 32'h0001_5000, 0, 0, 0);
    // R8 write protect; R9 no-execute
    wr(1, mk(1, 0, 4'd1, 0, 1, 1, 20'd1, 20'd40));
    access("R8", 32'h0002_8004, 0, 1, 0);
    access("R8", 32'h0002_8004, 0, 0, 0);
    access("R9", 32'h0002_8008, 0, 0, 1);
    access("R9", 32'h0002_8008, 0, 1, 1);
    // R11 reserved code and zero size
    wr(0, mk(1, 0, 4'd14, 1, 1, 1, 20'd4, 20'd60));
    wr(4, mk(1, 0, 4'd3, 1, 1, 1, 20'd0, 20'd61));
    access("R11", 32'h0003_D000, 0, 1, 0);
    // R10 relocation over a region
    wr(16, 20'd21);
    access("R10", 32'h0001_5FFC, 0, 1, 1);
    access("R10", 32'h0000_0015, 1, 0, 0);
    access("R10", 32'h000F_F000, 0, 0, 0);
    // R12 out-of-range index
    wr(20, mk(1, 0, 4'd5, 0, 0, 0, 20'd4, 20'd80));
    wr(17, 20'd90);
    access("R12", 32'h0005_1000, 0, 0, 0);
    access("R12", 32'h0001_5000, 0, 0, 0);
    // random descriptor sets
    for (int r = 0; r < 60; r++) begin
      for (int j = 0; j < 3; j++) begin
        int idx;
        idx = $urandom_range(NREG - 1, 0);
        wr(idx, mk($urandom_range(3, 0) != 0, $urandom_range(3, 0) == 0,
                   4'($urandom_range(15, 0)), 1'($urandom), 1'($urandom),
                   1'($urandom), 20'($urandom_range(12, 0)),
                   20'($urandom_range(48, 0))));
      end
      if ($urandom_range(7, 0) == 0) wr(16, 20'($urandom_range(60, 0)));
      for (int j = 0; j < 25; j++) begin
        bit io;
        bit [31:0] a;
        io = $urandom_range(3, 0) == 0;
        a = io ? 32'($urandom_range(63, 0)) :
                 {12'd0, 8'($urandom_range(63, 0)), 12'($urandom)};
        access(io ? "R3" : "R4", a, io, 1'($urandom), 1'($urandom));
      end
    end
    @(negedge clk);
    acc_valid = 0;
    @(posedge clk); #1;
    chk("R8", "idle viol_wp", viol_wp, 0);
    finish_run();
  end
endmodule